// File: doc/BRIEF.md
# Register-Mapped Word FIFO with Sticky Fault Status

This block is a word-wide first-in first-out buffer that is reached through a single-cycle register bus with byte enables. A bus write to the data window appends one word to the tail. A bus read from the same window removes the word at the head and returns it. A second window reports the fill state and any misuse. Both windows sit at fixed offsets from the block's register base.

Three kinds of misuse are caught and latched: appending while full, removing while empty, and touching the data window with anything less than all four byte enables. Each kind latches its own sticky flag. The flags are ORed into a single fault bit, which software can poll alone. Writing 1 to the fault bit clears all the latched faults together. Two threshold inputs set the levels at which the high-water and low-water indications assert.

Read data is registered. It appears on `bus_rdata` in the cycle after the read is sampled and holds until the next read.

Top module: `wordq_bus`

## Requirements
- R1: A full-word write to offset 0x3C stores the word. A full-word read at 0x3C returns the oldest stored word on `bus_rdata` one clock later and removes it, so words come back in the order they were written.
- R2: A read or write at 0x3C whose `bus_be` is not 4'hF neither stores nor removes a word. It sets the fault bit (status bit 22). Such a read returns zero.
- R3: A write at 0x3C while 16 words are held is discarded and leaves the contents unchanged. It sets the sticky overflow bit (status bit 20) and the fault bit.
- R4: A read at 0x3C while empty returns zero and removes nothing. It sets the sticky underflow bit (status bit 21) and the fault bit.
- R5: A read at offset 0x40 returns status in bits 22..16, ordered fault, underflow, overflow, full (bit 19), high (bit 18), low (bit 17), empty (bit 16). All other bits read as zero. Full and empty follow the current fill level and are not sticky.
- R6: The high bit is 1 exactly when the fill level is at or above `hi_level`. The low bit is 1 exactly when the fill level is at or below `lo_level`.
- R7: A write at 0x40 with `bus_be[2]` set and data bit 22 at 1 clears the fault, underflow, overflow and byte-enable fault. Writing 0 in bit 22 changes nothing.
- R8: After reset `bus_rdata` is zero, the buffer is empty and no fault is latched.
- R9: A status read has no side effects: it does not change the fill level or the stored words. A read at any unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW (8) | Byte offset from the block base |
| bus_be | input | DW/8 (4) | Byte enables |
| bus_wdata | input | DW (32) | Write data |
| hi_level | input | CW (5) | High-water threshold |
| lo_level | input | CW (5) | Low-water threshold |
| bus_rdata | output | DW (32) | Registered read data |

## Verification
The hardest states to reach from the ports are the boundaries of a full buffer. Here an overflow must leave the held words unchanged, and a byte-enable fault or a status read must not shift the level while the sticky bits are latched. Random traffic rarely reaches sixteen words, so directed phases fill the buffer to the brim, push past it, and drain it below empty. Weighted random traffic then mixes pushes, pops, partial-enable accesses, status reads and clears, and a bench model predicts every read word and status word.

// File: rtl/wq_pkg.sv
package wq_pkg;
   localparam int unsigned DATA_OFS = 32'h3C;
   localparam int unsigned STAT_OFS = 32'h40;
   localparam int unsigned FLAG_LSB = 16;
   localparam int unsigned FLAG_W   = 7;
   // flag vector positions inside the 7-bit field
   localparam int unsigned F_EMPTY = 0;
   localparam int unsigned F_LOW   = 1;
   localparam int unsigned F_HIGH  = 2;
   localparam int unsigned F_FULL  = 3;
   localparam int unsigned F_OVF   = 4;
   localparam int unsigned F_UNF   = 5;
   localparam int unsigned F_ERR   = 6;
endpackage

// File: rtl/wq_store.sv
module wq_store #(
   parameter int unsigned DW    = 32,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned IW   = $clog2(DEPTH),
   localparam int unsigned CW   = IW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_req,
   input  logic          pop_req,
   input  logic [DW-1:0] wr_word,
   output logic [DW-1:0] head_word,
   output logic [CW-1:0] level,
   output logic          is_full,
   output logic          is_empty,
   output logic          ovf_evt,
   output logic          unf_evt
);
   logic [DW-1:0] mem [DEPTH];
   logic [CW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign level     = wp - rp;
   assign is_full   = (level == CW'(DEPTH));
   assign is_empty  = (wp == rp);
   assign do_push   = push_req && !is_full;
   assign do_pop    = pop_req && !is_empty;
   assign ovf_evt   = push_req && is_full;
   assign unf_evt   = pop_req && is_empty;
   assign head_word = mem[rp[IW-1:0]];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp[IW-1:0]] <= wr_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
      end
   end

   a_r3_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && is_full) |=> $stable(wp));
   a_r4_empty_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && is_empty) |=> $stable(rp));
   a_r1_level_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CW'(DEPTH));
endmodule

// File: rtl/wq_flags.sv
module wq_flags
   import wq_pkg::*;
#(
   parameter int unsigned CW = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CW-1:0]     level,
   input  logic              is_full,
   input  logic              is_empty,
   input  logic [CW-1:0]     hi_level,
   input  logic [CW-1:0]     lo_level,
   input  logic              ovf_evt,
   input  logic              unf_evt,
   input  logic              acc_evt,
   input  logic              clr_req,
   output logic [FLAG_W-1:0] flags
);
   logic ovf_q, unf_q, acc_q;
   logic any_evt;

   assign any_evt = ovf_evt | unf_evt | acc_evt;

   // a fresh fault in the same cycle wins over a clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
         acc_q <= 1'b0;
      end else begin
         ovf_q <= ovf_evt | (ovf_q & ~(clr_req & ~any_evt));
         unf_q <= unf_evt | (unf_q & ~(clr_req & ~any_evt));
         acc_q <= acc_evt | (acc_q & ~(clr_req & ~any_evt));
      end
   end

   always_comb begin
      flags          = '0;
      flags[F_EMPTY] = is_empty;
      flags[F_LOW]   = (level <= lo_level);
      flags[F_HIGH]  = (level >= hi_level);
      flags[F_FULL]  = is_full;
      flags[F_OVF]   = ovf_q;
      flags[F_UNF]   = unf_q;
      flags[F_ERR]   = ovf_q | unf_q | acc_q;
   end

   a_r7_clear_drops_err: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !any_evt) |=> !flags[F_ERR]);
   a_r2_access_fault_latches: assert property (@(posedge clk) disable iff (!rst_n)
      acc_evt |=> flags[F_ERR]);
   a_r3_overflow_latches: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> (flags[F_OVF] && flags[F_ERR]));
   a_r4_underflow_latches: assert property (@(posedge clk) disable iff (!rst_n)
      unf_evt |=> (flags[F_UNF] && flags[F_ERR]));
endmodule

// File: rtl/wordq_bus.sv
module wordq_bus
   import wq_pkg::*;
#(
   parameter int unsigned DW    = 32,
   parameter int unsigned DEPTH = 16,
   parameter int unsigned AW    = 8,
   localparam int unsigned BW   = DW / 8,
   localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_sel,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [BW-1:0] bus_be,
   input  logic [DW-1:0] bus_wdata,
   input  logic [CW-1:0] hi_level,
   input  logic [CW-1:0] lo_level,
   output logic [DW-1:0] bus_rdata
);
   if (DW % 8 != 0 || DW < FLAG_LSB + FLAG_W) begin : g_bad_dw
      $error("wordq_bus: DW must be a byte multiple holding the flag field");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("wordq_bus: DEPTH must be a power of two, at least 2");
   end
   if (AW < 7) begin : g_bad_aw
      $error("wordq_bus: AW too narrow for the register offsets");
   end

   localparam int unsigned ERR_BIT  = FLAG_LSB + F_ERR;
   localparam int unsigned ERR_BYTE = ERR_BIT / 8;

   logic              hit_data, hit_stat, be_full;
   logic              push_req, pop_req, acc_evt, clr_req;
   logic [DW-1:0]     head_word, stat_word, rd_next;
   logic [CW-1:0]     level;
   logic              is_full, is_empty, ovf_evt, unf_evt;
   logic [FLAG_W-1:0] flags;
   logic [DW-1:0]     rdata_q;

   assign hit_data = bus_sel && (bus_addr == AW'(DATA_OFS));
   assign hit_stat = bus_sel && (bus_addr == AW'(STAT_OFS));
   assign be_full  = &bus_be;
   assign push_req = hit_data && bus_wr && be_full;
   assign pop_req  = hit_data && !bus_wr && be_full;
   assign acc_evt  = hit_data && !be_full;
   assign clr_req  = hit_stat && bus_wr && bus_be[ERR_BYTE] && bus_wdata[ERR_BIT];

   wq_store #(.DW(DW), .DEPTH(DEPTH)) store_i (
      .clk, .rst_n, .push_req, .pop_req, .wr_word(bus_wdata),
      .head_word, .level, .is_full, .is_empty, .ovf_evt, .unf_evt
   );

   wq_flags #(.CW(CW)) flags_i (
      .clk, .rst_n, .level, .is_full, .is_empty, .hi_level, .lo_level,
      .ovf_evt, .unf_evt, .acc_evt, .clr_req, .flags
   );

   always_comb begin
      stat_word = '0;
      stat_word[FLAG_LSB +: FLAG_W] = flags;
      rd_next = '0;
      if (pop_req && !is_empty) rd_next = head_word;
      else if (hit_stat)        rd_next = stat_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                rdata_q <= '0;
      else if (bus_sel && !bus_wr) rdata_q <= rd_next;
   end

   assign bus_rdata = rdata_q;

   a_r2_bad_be_no_move: assert property (@(posedge clk) disable iff (!rst_n)
      acc_evt |=> $stable(level));
   a_r9_status_read_no_move: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_stat && !bus_wr) |=> $stable(level));
   a_r4_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && is_empty) |=> (bus_rdata == '0));
endmodule

// File: tb/wordq_bus_tb_top.sv
module wordq_bus_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [4:0]  hi_level = 5'd12;
   logic [4:0]  lo_level = 5'd3;
   logic [31:0] bus_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model
   logic [31:0] q[$];
   bit m_ovf, m_unf, m_acc;

   always #2 clk = ~clk;

   wordq_bus dut_i (
      .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_be, .bus_wdata,
      .hi_level, .lo_level, .bus_rdata
   );

   function automatic logic [31:0] exp_status();
      logic [6:0] f;
      int n = q.size();
      f[0] = (n == 0);
      f[1] = (n <= int'(lo_level));
      f[2] = (n >= int'(hi_level));
      f[3] = (n == 16);
      f[4] = m_ovf;
      f[5] = m_unf;
      f[6] = m_ovf | m_unf | m_acc;
      return {9'd0, f, 16'd0};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic acc(input bit wr, input logic [7:0] a, input logic [3:0] be,
                      input logic [31:0] d, output logic [31:0] r);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_be = be; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      r = bus_rdata;
   endtask

   task automatic push(input logic [31:0] d);
      logic [31:0] r;
      acc(1'b1, 8'h3C, 4'hF, d, r);
      if (q.size() == 16) m_ovf = 1'b1;
      else q.push_back(d);
   endtask

   task automatic pop_check(input string tag);
      logic [31:0] r, e;
      acc(1'b0, 8'h3C, 4'hF, 32'h0, r);
      if (q.size() == 0) begin e = 32'h0; m_unf = 1'b1; end
      else e = q.pop_front();
      chk(tag, r, e);
   endtask

   task automatic stat_check(input string tag);
      logic [31:0] r, e;
      e = exp_status();
      acc(1'b0, 8'h40, 4'hF, 32'h0, r);
      chk(tag, r, e);
   endtask

   task automatic clear_err(input logic [31:0] d);
      logic [31:0] r;
      acc(1'b1, 8'h40, 4'hF, d, r);
      if (d[22]) begin m_ovf = 0; m_unf = 0; m_acc = 0; end
   endtask

   task automatic bad_access(input bit wr, input logic [3:0] be, input logic [31:0] d);
      logic [31:0] r;
      acc(wr, 8'h3C, be, d, r);
      m_acc = 1'b1;
      if (!wr) chk("R2 partial read returns zero", r, 32'h0);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      void'($urandom(32'h0BADC0DE));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 rdata after reset", bus_rdata, 32'h0);
      stat_check("R8 R5 status after reset");

      // R1 ordering
      for (int i = 0; i < 5; i++) push(32'hA000_0000 + i);
      stat_check("R6 R5 status at level 5");
      for (int i = 0; i < 5; i++) pop_check("R1 ordered pop");

      // R3 fill to full, then overflow
      for (int i = 0; i < 16; i++) push($urandom);
      stat_check("R5 R6 full and high");
      push(32'hDEAD_BEEF);
      stat_check("R3 overflow latched");
      // R9 status reads do not move level
      stat_check("R9 repeated status read");
      acc(1'b0, 8'h44, 4'hF, 32'h0, r);
      chk("R9 unmapped read zero", r, 32'h0);
      // R2 partial accesses at full level
      bad_access(1'b1, 4'h7, 32'h1234_5678);
      bad_access(1'b0, 4'hE, 32'h0);
      stat_check("R2 partial access no move");
      for (int i = 0; i < 16; i++) pop_check("R3 contents kept after overflow");
      // R4 underflow
      pop_check("R4 empty read zero");
      stat_check("R4 underflow latched");
      // R7 writing 0 changes nothing, writing 1 clears
      clear_err(32'hFFBF_FFFF);
      stat_check("R7 write zero keeps fault");
      clear_err(32'h0040_0000);
      stat_check("R7 write one clears");
      // R2 fault alone rolls up
      bad_access(1'b1, 4'h0, 32'h0);
      stat_check("R2 fault bit from byte enables");
      clear_err(32'h0040_0000);
      stat_check("R7 clear after byte-enable fault");

      // R6 threshold change at runtime
      for (int i = 0; i < 4; i++) push($urandom);
      hi_level = 5'd4; lo_level = 5'd4;
      stat_check("R6 level equals both thresholds");
      hi_level = 5'd5; lo_level = 5'd3;
      stat_check("R6 level between thresholds");
      hi_level = 5'd12;

      // random mix
      for (int n = 0; n < 1500; n++) begin
         int unsigned op = $urandom_range(0, 11);
         if (op < 5)       push($urandom);
         else if (op < 8)  pop_check("R1 random pop");
         else if (op < 10) stat_check("R5 R6 random status");
         else if (op < 11) bad_access(bit'($urandom_range(0, 1)), 4'($urandom_range(0, 14)), $urandom);
         else              clear_err({$urandom} & 32'hFFBF_FFFF | (($urandom_range(0, 1) != 0) ? 32'h0040_0000 : 32'h0));
      end
      stat_check("R5 final status");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule